// File: doc/BRIEF.md
# Passive-Serial Configuration Loader

This block loads a bitstream into an FPGA that is configured over a passive serial port. The port is controlled through an 8-bit pin image: a register whose bits drive the target's configuration pins. After a start pulse, the block drives a reboot burst that alternates between two pin images. It then drives a short preparation pattern. Next it parks the pins and waits for the target's ready line, which is active high and is sampled through a two-stage synchronizer.

Once the target is ready, the block takes bitstream bytes over a valid/ready handshake. It sends each byte most significant bit first. Every bit becomes two pin images: the first with the configuration clock high, the second with it low, and the data bit the same in both. Every pin image is held for a programmable number of clock cycles, which sets the configuration clock rate. A byte marked as last ends the load: the pins return to all-low and a done flag is raised. If the target never signals ready within a programmable number of cycles, the block raises an error flag, drives the pins low and stops. Both flags stay set until the next start pulse.

Top module: `pscfg_loader`

## Requirements
- R1: After reset, pin_out is 0x00, done and error are low, and byte_ready is low.
- R2: A start pulse while idle, done or failed launches a reboot burst of REBOOT_STATES pin images, alternating 0x84 (first) and 0x88. Each image is held for hold_cycles cycles, and a hold_cycles value of 0 acts as 1. The start pulse also clears done and error.
- R3: After the burst come PREP_HIGH images of 0x03, then PREP_LOW images of 0x01, each held for the same time.
- R4: After the preparation pattern, pin_out stays 0x01 and byte_ready stays low until cfg_ready_in is high. No byte is accepted before that. A high level on cfg_ready_in is acted on two clock edges after it is first sampled.
- R5: Each accepted byte is sent bit 7 first as 16 pin images. Bit i of the byte produces {0, b, 00000, 1} followed by {0, b, 00000, 0}, with the data on pin 6 and the clock on pin 0, and each image is held for the hold time.
- R6: byte_ready is high in the last cycle of a non-last byte's final image, so a waiting byte follows with no gap. It is low in that cycle for a byte marked last.
- R7: One cycle after the last byte's final image, pin_out is 0x00, done is high and byte_ready is low.
- R8: If cfg_ready_in has not been seen high within timeout_cycles cycles of entering the wait, error rises and pin_out goes to 0x00. Error stays high until start. A ready level seen in the same cycle as the expiry wins over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a configuration run when idle, done or failed |
| hold_cycles | input | HOLD_W | Cycles each pin image is held (0 acts as 1) |
| timeout_cycles | input | TO_W | Cycles allowed for the target to become ready |
| byte_data | input | 8 | Bitstream byte |
| byte_valid | input | 1 | byte_data is valid |
| byte_last | input | 1 | The offered byte is the final one |
| byte_ready | output | 1 | Byte is taken on this edge if byte_valid |
| cfg_ready_in | input | 1 | Target ready status (active high, asynchronous) |
| pin_out | output | 8 | Configuration pin image |
| done | output | 1 | Load completed |
| error | output | 1 | Target never became ready |

## Verification
The in-design assertions check on every cycle that:
- a pin image does not move between hold-timer steps;
- during shifting only the data and clock pins can be high;
- byte_ready appears only in the shifting phase;
- done and error are never high together, and both imply idle-low pins;
- error persists until start;
- the wait counter never passes its limit.

Only the bench's scenarios can show the rest: the exact order and duration of the reboot and preparation images, the most-significant-bit-first order, gap-free chaining of bytes, the exact cycle of the timeout, and the precedence of a ready level that arrives in the same cycle as the expiry.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REBOOT,
        PH_PREP,
        PH_WAIT,
        PH_SHIFT,
        PH_DONE,
        PH_FAIL
    } phase_e;

    localparam int CLK_PIN  = 0;
    localparam int DATA_PIN = 6;

    localparam logic [7:0] REBOOT_EVEN = 8'h84;
    localparam logic [7:0] REBOOT_ODD  = 8'h88;
    localparam logic [7:0] PREP_FIRST  = 8'h03;
    localparam logic [7:0] PREP_REST   = 8'h01;

    function automatic logic [7:0] bit_image(input logic d, input logic c);
        logic [7:0] img;
        img           = 8'h00;
        img[DATA_PIN] = d;
        img[CLK_PIN]  = c;
        return img;
    endfunction

endpackage

// File: rtl/pscfg_hold_timer.sv
module pscfg_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              step
);
    logic [HOLD_W-1:0] cnt_d, cnt_q;
    logic [HOLD_W-1:0] limit;

    always_comb begin
        limit = (hold_cycles == '0) ? '0 : hold_cycles - 1'b1;
        step  = run && (cnt_q >= limit);
        cnt_d = (!run || step) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/pscfg_init_watch.sv
module pscfg_init_watch #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ready_raw,
    input  logic            arm,
    input  logic [TO_W-1:0] timeout_cycles,
    output logic            ready_seen,
    output logic            timed_out
);
    typedef struct packed {
        logic            s1;
        logic            s2;
        logic [TO_W-1:0] cnt;
    } watch_t;

    watch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = ready_raw;
        st_d.s2   = st_q.s1;
        timed_out = arm && (st_q.cnt == timeout_cycles);
        ready_seen = arm && st_q.s2;
        if (!arm)           st_d.cnt = '0;
        else if (!timed_out) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WAIT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (st_q.cnt <= timeout_cycles)); // R8
endmodule

// File: rtl/pscfg_loader.sv
module pscfg_loader
    import pscfg_pkg::*;
#(
    parameter int HOLD_W        = 8,
    parameter int TO_W          = 16,
    parameter int REBOOT_STATES = 8,
    parameter int PREP_HIGH     = 2,
    parameter int PREP_LOW      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [TO_W-1:0]   timeout_cycles,
    input  logic [7:0]        byte_data,
    input  logic              byte_valid,
    input  logic              byte_last,
    output logic              byte_ready,
    input  logic              cfg_ready_in,
    output logic [7:0]        pin_out,
    output logic              done,
    output logic              error
);
    localparam int PREP_STATES = PREP_HIGH + PREP_LOW;
    localparam int MAX_STATES  = (REBOOT_STATES > PREP_STATES) ? REBOOT_STATES : PREP_STATES;
    localparam int IDX_W       = $clog2(MAX_STATES + 1);
    localparam logic [IDX_W-1:0] REBOOT_END = IDX_W'(REBOOT_STATES - 1);
    localparam logic [IDX_W-1:0] PREP_END   = IDX_W'(PREP_STATES - 1);
    localparam logic [IDX_W-1:0] PREP_SPLIT = IDX_W'(PREP_HIGH);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic [7:0]       shreg;
        logic [2:0]       bitn;
        logic             low_half;
        logic             have_byte;
        logic             last_byte;
        logic [7:0]       pin;
        logic             done;
        logic             err;
    } state_t;

    state_t st_d, st_q;
    logic   run, step, arm, ready_seen, timed_out, final_img;
    logic [IDX_W-1:0] idx_nx;

    pscfg_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run),
        .hold_cycles(hold_cycles), .step(step)
    );

    pscfg_init_watch #(.TO_W(TO_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .ready_raw(cfg_ready_in), .arm(arm),
        .timeout_cycles(timeout_cycles),
        .ready_seen(ready_seen), .timed_out(timed_out)
    );

    always_comb begin
        run = (st_q.phase == PH_REBOOT) || (st_q.phase == PH_PREP) ||
              ((st_q.phase == PH_SHIFT) && st_q.have_byte);
        arm = (st_q.phase == PH_WAIT);
        final_img = st_q.have_byte && st_q.low_half && (st_q.bitn == 3'd0) && step;
        byte_ready = (st_q.phase == PH_SHIFT) &&
                     (!st_q.have_byte || (final_img && !st_q.last_byte));
        idx_nx = st_q.idx + 1'b1;
        st_d   = st_q;

        case (st_q.phase)
            PH_IDLE, PH_DONE, PH_FAIL: begin
                if (start) begin
                    st_d.phase     = PH_REBOOT;
                    st_d.idx       = '0;
                    st_d.pin       = REBOOT_EVEN;
                    st_d.done      = 1'b0;
                    st_d.err       = 1'b0;
                    st_d.have_byte = 1'b0;
                end
            end
            PH_REBOOT: begin
                if (step) begin
                    if (st_q.idx == REBOOT_END) begin
                        st_d.phase = PH_PREP;
                        st_d.idx   = '0;
                        st_d.pin   = (PREP_HIGH > 0) ? PREP_FIRST : PREP_REST;
                    end else begin
                        st_d.idx = idx_nx;
                        st_d.pin = idx_nx[0] ? REBOOT_ODD : REBOOT_EVEN;
                    end
                end
            end
            PH_PREP: begin
                if (step) begin
                    if (st_q.idx == PREP_END) begin
                        st_d.phase = PH_WAIT;
                    end else begin
                        st_d.idx = idx_nx;
                        st_d.pin = (idx_nx < PREP_SPLIT) ? PREP_FIRST : PREP_REST;
                    end
                end
            end
            PH_WAIT: begin
                if (ready_seen) begin
                    st_d.phase = PH_SHIFT;
                end else if (timed_out) begin
                    st_d.phase = PH_FAIL;
                    st_d.pin   = 8'h00;
                    st_d.err   = 1'b1;
                end
            end
            PH_SHIFT: begin
                if (st_q.have_byte && step) begin
                    if (!st_q.low_half) begin
                        st_d.pin      = bit_image(st_q.shreg[7], 1'b0);
                        st_d.low_half = 1'b1;
                    end else if (st_q.bitn != 3'd0) begin
                        st_d.shreg    = {st_q.shreg[6:0], 1'b0};
                        st_d.bitn     = st_q.bitn - 3'd1;
                        st_d.low_half = 1'b0;
                        st_d.pin      = bit_image(st_q.shreg[6], 1'b1);
                    end else begin
                        st_d.have_byte = 1'b0;
                        if (st_q.last_byte) begin
                            st_d.phase = PH_DONE;
                            st_d.pin   = 8'h00;
                            st_d.done  = 1'b1;
                        end
                    end
                end
                if (byte_ready && byte_valid) begin
                    st_d.shreg     = byte_data;
                    st_d.last_byte = byte_last;
                    st_d.bitn      = 3'd7;
                    st_d.low_half  = 1'b0;
                    st_d.have_byte = 1'b1;
                    st_d.pin       = bit_image(byte_data[7], 1'b1);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out = st_q.pin;
    assign done    = st_q.done;
    assign error   = st_q.err;

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step) |=> $stable(pin_out)); // R2
    AST_SHIFT_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SHIFT && st_q.have_byte) |-> ((pin_out & 8'hBE) == 8'h00)); // R5
    AST_READY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (st_q.phase == PH_SHIFT)); // R4
    AST_FLAGS_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (pin_out == 8'h00)); // R7
    AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error); // R8
endmodule

// File: tb/pscfg_loader_tb.sv
module pscfg_loader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] hold_cycles = 8'd1;
    logic [15:0] timeout_cycles = 16'd1000;
    logic [7:0] byte_data = 8'h00;
    logic       byte_valid = 1'b0;
    logic       byte_last = 1'b0;
    logic       byte_ready;
    logic       cfg_ready_in = 1'b0;
    logic [7:0] pin_out;
    logic       done, error;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    localparam int NSCEN = 3;
    localparam int BPS   = 2;
    localparam logic [7:0] HOLDS [NSCEN] = '{8'd1, 8'd3, 8'd0};
    localparam logic [7:0] BYTES [NSCEN*BPS] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81, 8'h6E};
    localparam int TMO = 20;

    always #2 clk = ~clk;

    pscfg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hold_cycles(hold_cycles),
        .timeout_cycles(timeout_cycles), .byte_data(byte_data),
        .byte_valid(byte_valid), .byte_last(byte_last), .byte_ready(byte_ready),
        .cfg_ready_in(cfg_ready_in), .pin_out(pin_out), .done(done), .error(error)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 50000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] img(input logic d, input logic c);
        return {1'b0, d, 5'b00000, c};
    endfunction

    task automatic check_state(input logic [7:0] exp, input int he, input string req);
        bit bad = 1'b0;
        logic [7:0] seen = exp;
        for (int c = 0; c < he; c++) begin
            @(negedge clk);
            if (pin_out !== exp) begin bad = 1'b1; seen = pin_out; end
        end
        chk(!bad, req, {8'h00, seen}, {8'h00, exp});
    endtask

    task automatic start_seq();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic lead_in(input int he);
        start_seq();
        for (int k = 0; k < 8; k++)
            check_state((k % 2 == 1) ? 8'h88 : 8'h84, he, "R2 reboot image");
        for (int k = 0; k < 9; k++)
            check_state((k < 2) ? 8'h03 : 8'h01, he, "R3 prep image");
    endtask

    task automatic run_scenario(input int sc);
        int he;
        int w;
        logic [7:0] cur;
        hold_cycles = HOLDS[sc];
        he = (HOLDS[sc] == 8'd0) ? 1 : int'(HOLDS[sc]);
        lead_in(he);
        byte_data  = BYTES[sc*BPS];
        byte_last  = 1'b0;
        byte_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(pin_out == 8'h01 && !byte_ready, "R4 parked while not ready",
                {7'd0, byte_ready, pin_out}, 16'h0001);
        end
        cfg_ready_in = 1'b1;
        w = 0;
        do begin @(negedge clk); w++; end while (!byte_ready && w < 20);
        chk(byte_ready, "R4 ready after target ready", {15'd0, byte_ready}, 16'd1);
        for (int i = 0; i < BPS; i++) begin
            cur = BYTES[sc*BPS + i];
            @(posedge clk);
            for (int s = 0; s < 16; s++) begin
                check_state(img(cur[7 - s/2], (s % 2 == 0)), he, "R5 bit image");
                if (s == 0) begin
                    if (i < BPS - 1) begin
                        byte_data = BYTES[sc*BPS + i + 1];
                        byte_last = (i + 1 == BPS - 1);
                    end else begin
                        byte_valid = 1'b0;
                    end
                end
            end
            chk(byte_ready == (i < BPS - 1), "R6 ready at final image",
                {15'd0, byte_ready}, {15'd0, (i < BPS - 1)});
        end
        @(negedge clk);
        chk(pin_out == 8'h00 && done && !byte_ready && !error, "R7 done and pins low",
            {6'd0, done, byte_ready, pin_out}, 16'h0200);
        cfg_ready_in = 1'b0;
        byte_last = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pin_out == 8'h00 && !done && !error && !byte_ready, "R1 reset state",
            {5'd0, done, error, byte_ready, pin_out}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_out == 8'h00 && !byte_ready, "R1 idle after reset",
            {7'd0, byte_ready, pin_out}, 16'h0000);

        for (int sc = 0; sc < NSCEN; sc++) run_scenario(sc);

        // R8: timeout with target never ready; R2: restart clears done
        hold_cycles = 8'd1;
        timeout_cycles = 16'(TMO);
        byte_valid = 1'b1;
        byte_data = 8'h5A;
        lead_in(1);
        chk(!done, "R2 start clears done", {15'd0, done}, 16'd0);
        begin
            bit bad = 1'b0;
            for (int j = 0; j <= TMO; j++) begin
                @(negedge clk);
                if (error || pin_out != 8'h01 || byte_ready) bad = 1'b1;
            end
            chk(!bad, "R8 no error before limit", {15'd0, bad}, 16'd0);
        end
        @(negedge clk);
        chk(error && pin_out == 8'h00 && !done, "R8 error at limit",
            {6'd0, done, error, pin_out}, 16'h0100);
        repeat (5) @(negedge clk);
        chk(error && !byte_ready, "R8 error sticky", {14'd0, error, byte_ready}, 16'h0002);

        // R8 boundary: ready arriving in the expiry cycle wins
        byte_valid = 1'b0;
        lead_in(1);
        chk(!error, "R2 start clears error", {15'd0, error}, 16'd0);
        repeat (TMO - 1) @(negedge clk);
        cfg_ready_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(!error && byte_ready, "R8 ready wins over expiry",
            {14'd0, error, byte_ready}, 16'h0001);

        summary();
    end
endmodule